// File: doc/BRIEF.md
# Standard Event Status Register Unit

This block holds the eight-bit sticky event register that an instrument's status reporting uses. Each condition is a separate single-cycle event strobe, and each strobe sets one bit of the register. A set bit stays set until a read-and-clear query. The query strobe shows the register value in the same cycle on the value output. At the next clock edge the register returns to zero. One bit position, request control, is tied to zero and can never be set.

An eight-bit enable mask is loaded through a write port and read back on its own output. The summary output is 1 whenever the register ANDed with the mask is nonzero. That output feeds bit 5 of an external status byte. Query errors and device-dependent errors also send a one-cycle push toward an external error queue, together with a code that tells which error class caused it.

Top module: `evstat_unit`

## Requirements
- R1: After reset the event register reads 8'h80 (only the power-on bit, bit 7), the mask reads 8'h00, and both summary and errq_push are 0.
- R2: A strobe sets its bit at the next rising edge: opc_stb sets bit 0, qerr_stb bit 2, dderr_stb bit 3, exerr_stb bit 4, cmderr_stb bit 5 and usr_stb bit 6. Bit 7 is power-on.
- R3: Bit 1 of esr_value (request control) is 0 at all times, whatever the inputs.
- R4: A set bit stays set on every following cycle until a cycle in which rdclr_stb is 1.
- R5: While rdclr_stb is 1, esr_value shows the register as it is. After that edge the register is 8'h00, apart from the case in R6. For example, power-on plus query error reads 8'h84 (132).
- R6: When an event strobe and rdclr_stb are high in the same cycle, esr_value in that cycle does not include the event, but the event's bit is set after the clear.
- R7: With mask_we at 1, mask_wdata is stored at the edge and shows on mask_value from the next cycle, all eight bits as written. With mask_we at 0, the mask keeps its value.
- R8: summary is 1 exactly when (esr_value & mask_value) is nonzero. It follows the registered values with no added delay.
- R9: errq_push is 1 for the one cycle after a cycle in which qerr_stb or dderr_stb is 1. In that cycle errq_kind[0] tells that a query error occurred and errq_kind[1] tells that a device-dependent error occurred. Otherwise errq_push is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opc_stb | input | 1 | Operation-complete event strobe |
| qerr_stb | input | 1 | Query error event strobe |
| dderr_stb | input | 1 | Device-dependent error event strobe |
| exerr_stb | input | 1 | Execution error event strobe |
| cmderr_stb | input | 1 | Command error event strobe |
| usr_stb | input | 1 | User request event strobe |
| rdclr_stb | input | 1 | Read-and-clear query strobe |
| esr_value | output | 8 | Current event register value |
| mask_we | input | 1 | Enable mask write strobe |
| mask_wdata | input | 8 | Enable mask write data |
| mask_value | output | 8 | Current enable mask |
| summary | output | 1 | Masked event summary (status byte bit 5) |
| errq_push | output | 1 | One-cycle push request toward the error queue |
| errq_kind | output | 2 | Error class of the push: bit 0 query, bit 1 device-dependent |

## Verification
The vector table drives one event source at a time. This shows that each strobe lands on its own bit position and on no other. The masks are chosen to cover or miss that bit, so the summary has to follow the AND of register and mask and not simply the register. One vector drives every strobe at once with a mask that covers only the request-control bit. This separates a correct bit 1 that is tied low from one that can be set. Directed tests then look at the value seen during a query, a query in the same cycle as an event, bits that persist over idle cycles, and power-on as the only summary source.

// File: rtl/evstat_unit.sv
module evstat_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opc_stb,
  input  logic       qerr_stb,
  input  logic       dderr_stb,
  input  logic       exerr_stb,
  input  logic       cmderr_stb,
  input  logic       usr_stb,
  input  logic       rdclr_stb,
  output logic [7:0] esr_value,
  input  logic       mask_we,
  input  logic [7:0] mask_wdata,
  output logic [7:0] mask_value,
  output logic       summary,
  output logic       errq_push,
  output logic [1:0] errq_kind
);
  localparam logic [7:0] PWRUP_VAL = 8'h80;

  logic [7:0] ev_q, mask_q, ev_set, ev_d;
  logic       push_q;
  logic [1:0] kind_q;

  assign ev_set = {1'b0, usr_stb, cmderr_stb, exerr_stb, dderr_stb, qerr_stb, 1'b0, opc_stb};
  assign ev_d   = (rdclr_stb ? 8'h00 : ev_q) | ev_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q   <= PWRUP_VAL;
      mask_q <= 8'h00;
      push_q <= 1'b0;
      kind_q <= 2'b00;
    end else begin
      ev_q   <= ev_d;
      if (mask_we) mask_q <= mask_wdata;
      push_q <= qerr_stb | dderr_stb;
      kind_q <= {dderr_stb, qerr_stb};
    end
  end

  assign esr_value  = ev_q;
  assign mask_value = mask_q;
  assign summary    = |(ev_q & mask_q);
  assign errq_push  = push_q;
  assign errq_kind  = kind_q;
endmodule

module evstat_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       opc_stb,
  input logic       qerr_stb,
  input logic       dderr_stb,
  input logic       exerr_stb,
  input logic       cmderr_stb,
  input logic       usr_stb,
  input logic       rdclr_stb,
  input logic [7:0] esr_value,
  input logic       mask_we,
  input logic [7:0] mask_wdata,
  input logic [7:0] mask_value,
  input logic       summary,
  input logic       errq_push,
  input logic [1:0] errq_kind
);
  logic any_ev;
  assign any_ev = opc_stb | qerr_stb | dderr_stb | exerr_stb | cmderr_stb | usr_stb;

  AST_RQC_ZERO: assert property (@(posedge clk) disable iff (!rst_n) esr_value[1] == 1'b0); // R3
  AST_OPC_SETS: assert property (@(posedge clk) disable iff (!rst_n) opc_stb |=> esr_value[0]); // R2
  AST_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rdclr_stb |=> ((esr_value & $past(esr_value)) == $past(esr_value))); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdclr_stb && !any_ev) |=> (esr_value == 8'h00)); // R5
  AST_COINCIDENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rdclr_stb && qerr_stb) |=> esr_value[2]); // R6
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_value == $past(mask_wdata))); // R7
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_value)); // R7
  AST_NO_SUMMARY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_value == 8'h00) |-> !summary); // R8
  AST_PUSH_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (qerr_stb || dderr_stb) |=> errq_push); // R9
  AST_NO_PUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(qerr_stb || dderr_stb) |=> !errq_push); // R9
endmodule

bind evstat_unit evstat_unit_chk u_chk (.*);

// File: tb/evstat_unit_tb.sv
module evstat_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic opc_stb = 0, qerr_stb = 0, dderr_stb = 0, exerr_stb = 0, cmderr_stb = 0, usr_stb = 0;
  logic rdclr_stb = 0, mask_we = 0;
  logic [7:0] mask_wdata = 8'h00;
  logic [7:0] esr_value, mask_value;
  logic summary, errq_push;
  logic [1:0] errq_kind;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  evstat_unit u_dut (.*);

  // {events user,cmd,exec,dev,qerr,opc ; mask ; expected register ; expected summary}
  localparam int NV = 8;
  localparam logic [22:0] VEC [NV] = '{
    {6'b000001, 8'h01, 8'h01, 1'b1},
    {6'b000010, 8'h01, 8'h04, 1'b0},
    {6'b000100, 8'h08, 8'h08, 1'b1},
    {6'b001000, 8'hFF, 8'h10, 1'b1},
    {6'b010000, 8'hDF, 8'h20, 1'b0},
    {6'b100000, 8'h40, 8'h40, 1'b1},
    {6'b111111, 8'h02, 8'h7D, 1'b0},
    {6'b000000, 8'hFF, 8'h00, 1'b0}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ev(input logic [5:0] ev);
    {usr_stb, cmderr_stb, exerr_stb, dderr_stb, qerr_stb, opc_stb} = ev;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h1, 8'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk("R1 reset register", esr_value, 8'h80);
    chk("R1 reset mask", mask_value, 8'h00);
    chk("R1 reset summary", {7'd0, summary}, 8'h00);
    chk("R1 reset push", {7'd0, errq_push}, 8'h00);

    mask_we = 1; mask_wdata = 8'h80; tick(); mask_we = 0;
    chk("R8 power-on summary", {7'd0, summary}, 8'h01);
    chk("R7 mask readback", mask_value, 8'h80);

    qerr_stb = 1; tick(); qerr_stb = 0;
    chk("R9 push on query error", {6'd0, errq_kind}, 8'h01);
    chk("R9 push strobe", {7'd0, errq_push}, 8'h01);
    rdclr_stb = 1; #1;
    chk("R5 query value 132", esr_value, 8'd132);
    tick(); rdclr_stb = 0;
    chk("R5 cleared after query", esr_value, 8'h00);
    chk("R9 push one cycle", {7'd0, errq_push}, 8'h00);
    chk("R8 summary off when cleared", {7'd0, summary}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [5:0] ev; logic [7:0] m, e; logic s;
      {ev, m, e, s} = VEC[i];
      rdclr_stb = 1; tick(); rdclr_stb = 0;
      set_ev(ev); mask_we = 1; mask_wdata = m;
      tick();
      set_ev(6'd0); mask_we = 0;
      chk("R2/R3 event bits", esr_value, e);
      chk("R7 mask", mask_value, m);
      chk("R8 summary", {7'd0, summary}, {7'd0, s});
      chk("R9 push", {5'd0, errq_push, errq_kind}, {5'd0, ev[1] | ev[2], ev[2], ev[1]});
    end

    opc_stb = 1; rdclr_stb = 1; #1;
    chk("R6 coincident excluded", esr_value, 8'h00);
    tick(); opc_stb = 0; rdclr_stb = 0;
    chk("R6 coincident kept", esr_value, 8'h01);
    usr_stb = 1; tick(); usr_stb = 0;
    repeat (3) tick();
    chk("R4 sticky bits", esr_value, 8'h41);

    mask_we = 1; mask_wdata = 8'hFF; tick(); mask_we = 0;
    set_ev(6'h3F); tick(); set_ev(6'd0);
    chk("R3 request control zero", {7'd0, esr_value[1]}, 8'h00);
    chk("R7 mask bit1 stored", mask_value, 8'hFF);
    mask_wdata = 8'h00; tick();
    chk("R7 mask holds without write", mask_value, 8'hFF);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule